// File: doc/BRIEF.md
# LED Connectivity Test Sequencer

This block runs a production test of five current-sink outputs: four LED channels and one flash channel. The test port has two pins. The tester toggles a clock pin, and the block answers on a result pin. On the first high phase of the clock pin the block returns a device acknowledge. On each later high phase it returns one channel's pass flag. The channels come in a fixed order: LED1, LED2, LED3, LED4, then flash. One more high phase closes the sequence, and after that the result pin stays low. The result pin is held low whenever the clock pin is low. The pass/fail decision for each channel comes from analog comparators outside this block, which deliver one digital flag per channel.

The pin sequence depends only on the block's power-on reset. The register reset input has no effect on it.

For use in the field, the block also has one register, the test register. Writing it with bit 0 set starts a self-test. The self-test samples the five channel flags one per clock, stores a result bit for each, and then clears bit 0. The stored results stay readable until the next start.

Top module: `conn_test_seq`

## Requirements
- R1: While the synchronized test clock is low, `t2_out` is 0. This includes the whole time power-on reset is active.
- R2: During the first `t1_in` high phase after power-on reset, `t2_out` equals `dev_ok`. A faulty device (`dev_ok`=0) therefore answers 0.
- R3: High phases 2 to 6 present `chan_ok[0]`..`chan_ok[4]` in that order. These are LED1, LED2, LED3, LED4 and flash.
- R4: During the 7th high phase, and every high phase after it, `t2_out` stays 0 until the next power-on reset.
- R5: Pulsing `reg_rst` does not disturb the position or output of the pin sequence.
- R6: `t2_out` follows a `t1_in` rising edge exactly 3 clocks later: 2 synchronizer stages plus 1 output register.
- R7: A write of a value with bit 0 set to address 0x0C while the block is idle starts a self-test. Bit 0 of the register then reads 1 for exactly 5 cycles and then 0.
- R8: After a self-test, register bits 7..3 hold the results for LED1, LED2, LED3, LED4 and flash, in that order. Bits 2..1 read 0, and a channel's bit is 1 when it passed.
- R9: The self-test samples one flag per clock, LED1 first, in the cycle after the start write. A flag that changes after its slot has been sampled does not alter its result.
- R10: The result bits are read-only. A write to 0x0C with bit 0 clear leaves them unchanged. A write to any other address starts nothing. A read of any other address returns 0.
- R11: The results hold until the next start, whatever the flags do in the meantime. `reg_rst` clears the whole register to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| reg_rst | input | 1 | Synchronous register reset (field test only) |
| t1_in | input | 1 | Test clock pin, asynchronous |
| t2_out | output | 1 | Test result pin |
| dev_ok | input | 1 | Device acknowledge flag |
| chan_ok | input | 5 | Per-channel pass flags, bit 0 = LED1, bit 4 = flash |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |

## Verification
The case that is hardest to reach from the ports is proving that the self-test samples the flags one at a time rather than all at once. The stimulus starts a run with all flags high. In the cycle after LED1's slot has passed, it drops both the LED1 flag and the flash flag. A sequential scan must then keep LED1 as passed and record flash as failed. A second hard case is the end of the pin pattern: the sequence is walked through its closing phase and one phase beyond it, with a register reset injected part way through.

// File: rtl/lct_pkg.sv
package lct_pkg;

    localparam int CH_COUNT   = 5;
    localparam int REG_W      = 8;
    localparam int ADDR_W     = 8;
    localparam int SYNC_DEPTH = 2;
    localparam logic [ADDR_W-1:0] TEST_REG_ADDR = 8'h0C;

    // phases: ack, one per channel, final, then parked
    localparam int STEP_W = $clog2(CH_COUNT + 3);

    typedef enum logic [0:0] {
        FT_IDLE = 1'b0,
        FT_SCAN = 1'b1
    } ft_state_e;

    // register bit holding channel ch: first channel at the top bit
    function automatic int result_bit(input int ch, input int dw);
        return dw - 1 - ch;
    endfunction

endpackage

// File: rtl/lct_sync.sv
module lct_sync #(
    parameter int STAGES = lct_pkg::SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/lct_pin_seq.sv
module lct_pin_seq #(
    parameter int NCH = lct_pkg::CH_COUNT,
    parameter int SW  = lct_pkg::STEP_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           t1_s,
    input  logic           dev_ok,
    input  logic [NCH-1:0] flags,
    output logic           t2
);
    localparam logic [SW-1:0] STEP_LASTCH = SW'(NCH);
    localparam logic [SW-1:0] STEP_DONE   = SW'(NCH + 2);

    logic          t1_d;
    logic [SW-1:0] step_q;
    logic [SW-1:0] ch_idx;
    logic          sel;
    logic          t2_q;
    logic          fall;

    assign fall   = t1_d && !t1_s;
    assign ch_idx = step_q - 1'b1;

    always_comb begin
        sel = 1'b0;
        if (step_q == '0)               sel = dev_ok;
        else if (step_q <= STEP_LASTCH) sel = flags[ch_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t1_d   <= 1'b0;
            step_q <= '0;
            t2_q   <= 1'b0;
        end else begin
            t1_d <= t1_s;
            if (fall && step_q != STEP_DONE) step_q <= step_q + 1'b1;
            t2_q <= t1_s && sel;
        end
    end

    assign t2 = t2_q;

    // R1
    t2_low_chk: assert property (@(posedge clk) disable iff (rst)
        !t1_s |=> !t2_q);

    // R4
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (step_q == STEP_DONE) |=> (!t2_q && step_q == STEP_DONE));

    // R3
    step_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (t1_s && t1_d) |=> $stable(step_q));
endmodule

// File: rtl/lct_field_test.sv
module lct_field_test
    import lct_pkg::*;
#(
    parameter int NCH = CH_COUNT,
    parameter int DW  = REG_W,
    parameter int AW  = ADDR_W,
    parameter logic [AW-1:0] ADDR = TEST_REG_ADDR
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           wr,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    input  logic [NCH-1:0] flags,
    output logic [DW-1:0]  rdata
);
    localparam int IW = $clog2(NCH);
    localparam logic [IW-1:0] IDX_LAST = IW'(NCH - 1);

    ft_state_e      st_q;
    logic [IW-1:0]  idx_q;
    logic [NCH-1:0] ok_q;
    logic           start;
    logic [DW-1:0]  img;

    assign start = wr && (addr == ADDR) && wdata[0] && (st_q == FT_IDLE);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st_q  <= FT_IDLE;
            idx_q <= '0;
            ok_q  <= '0;
        end else begin
            case (st_q)
                FT_IDLE: if (start) begin
                    ok_q  <= '0;
                    idx_q <= '0;
                    st_q  <= FT_SCAN;
                end
                FT_SCAN: begin
                    ok_q[idx_q] <= flags[idx_q];
                    if (idx_q == IDX_LAST) st_q <= FT_IDLE;
                    else                   idx_q <= idx_q + 1'b1;
                end
                default: st_q <= FT_IDLE;
            endcase
        end
    end

    always_comb begin
        img = '0;
        for (int i = 0; i < NCH; i++) img[result_bit(i, DW)] = ok_q[i];
        img[0] = (st_q == FT_SCAN);
        rdata  = (addr == ADDR) ? img : '0;
    end

    // R7
    scan_end_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == FT_SCAN && idx_q == IDX_LAST && !clr) |=> (st_q == FT_IDLE));

    // R9
    scan_step_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == FT_SCAN && idx_q != IDX_LAST && !clr)
        |=> (st_q == FT_SCAN && idx_q == $past(idx_q) + 1'b1));

    // R10
    ok_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == FT_IDLE && !start && !clr) |=> $stable(ok_q));
endmodule

// File: rtl/conn_test_seq.sv
module conn_test_seq
    import lct_pkg::*;
#(
    parameter int NCH  = CH_COUNT,
    parameter int DW   = REG_W,
    parameter int AW   = ADDR_W,
    parameter int SYNC = SYNC_DEPTH,
    parameter logic [AW-1:0] ADDR = TEST_REG_ADDR
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_rst,
    input  logic           t1_in,
    output logic           t2_out,
    input  logic           dev_ok,
    input  logic [NCH-1:0] chan_ok,
    input  logic           reg_wr,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata
);
    localparam int SW = $clog2(NCH + 3);

    logic t1_s;

    lct_sync #(.STAGES(SYNC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (t1_in),
        .q   (t1_s)
    );

    lct_pin_seq #(.NCH(NCH), .SW(SW)) u_pin (
        .clk    (clk),
        .rst    (rst),
        .t1_s   (t1_s),
        .dev_ok (dev_ok),
        .flags  (chan_ok),
        .t2     (t2_out)
    );

    lct_field_test #(.NCH(NCH), .DW(DW), .AW(AW), .ADDR(ADDR)) u_field (
        .clk   (clk),
        .rst   (rst),
        .clr   (reg_rst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .flags (chan_ok),
        .rdata (reg_rdata)
    );
endmodule

// File: tb/test_conn_test_seq.sv
module test_conn_test_seq;
    localparam int PH = 40;

    logic       clk = 1'b0;
    logic       rst, reg_rst, t1, dev_ok, wr;
    logic [4:0] chan;
    logic [7:0] addr, wdata;
    logic       t2;
    logic [7:0] rdata;

    always #2.5 clk = ~clk;

    conn_test_seq i_conn_test_seq (
        .clk(clk), .rst(rst), .reg_rst(reg_rst), .t1_in(t1), .t2_out(t2),
        .dev_ok(dev_ok), .chan_ok(chan), .reg_wr(wr), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata)
    );

    typedef struct { logic v; string tag; } exp_t;
    exp_t sbq[$];
    event smp_ev;
    int checks = 0;
    int fails  = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // monitor: pops one expected item per sample request
    initial begin
        forever begin
            @(smp_ev);
            if (sbq.size() == 0) chk("scoreboard underrun", 32'd1, 32'd0);
            else begin
                exp_t it;
                it = sbq.pop_front();
                chk(it.tag, 32'(t2), 32'(it.v));
            end
        end
    end

    // driver: one phase of the test clock pin, expectation sampled mid-phase
    task automatic phase(input logic lvl, input logic expv, input string tag);
        t1 = lvl;
        repeat (PH/2) @(negedge clk);
        sbq.push_back('{expv, tag});
        ->smp_ev;
        repeat (PH/2) @(negedge clk);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        addr = 8'h0C;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        int n;
        rst = 1; reg_rst = 0; t1 = 0; dev_ok = 1; chan = 5'b10110;
        wr = 0; addr = 8'h0C; wdata = 0;
        repeat (5) @(negedge clk);
        chk("R1 low during reset", 32'(t2), 0);
        chk("R11 register reset value", 32'(rdata), 32'h00);
        rst = 0;
        repeat (PH) @(negedge clk);
        chk("R1 idle low", 32'(t2), 0);

        // R6 latency on first rising edge
        t1 = 1;
        @(negedge clk); @(negedge clk);
        chk("R6 not yet after 2 clocks", 32'(t2), 0);
        @(negedge clk);
        chk("R6 high after 3 clocks", 32'(t2), 1);
        phase(1'b1, 1'b1, "R2 device ack");
        phase(1'b0, 1'b0, "R1 low phase");

        for (int i = 0; i < 5; i++) begin
            if (i == 2) begin
                reg_rst = 1; @(negedge clk); reg_rst = 0;
                phase(1'b1, chan[i], "R5 channel after register reset");
            end else begin
                phase(1'b1, chan[i], "R3 channel pass bit");
            end
            phase(1'b0, 1'b0, "R1 low phase");
        end
        phase(1'b1, 1'b0, "R4 final phase");
        phase(1'b0, 1'b0, "R1 low phase");
        phase(1'b1, 1'b0, "R4 after end");
        phase(1'b0, 1'b0, "R1 low phase");

        // field self-test
        chan = 5'b01111;
        reg_write(8'h0C, 8'h01);
        n = 0;
        while (rdata[0] && n < 100) begin n++; @(negedge clk); end
        chk("R7 busy length", 32'(n), 5);
        chk("R8 result layout", 32'(rdata), 32'hF0);

        reg_write(8'h0C, 8'hF8);
        @(negedge clk);
        chk("R10 read-only results", 32'(rdata), 32'hF0);
        reg_write(8'h0B, 8'h01);
        addr = 8'h0B; @(negedge clk);
        chk("R10 other address reads 0", 32'(rdata), 0);
        addr = 8'h0C; @(negedge clk);
        chk("R10 other address starts nothing", 32'(rdata), 32'hF0);

        chan = 5'b00000;
        repeat (10) @(negedge clk);
        chk("R11 results held", 32'(rdata), 32'hF0);

        // R9 sequential sampling: LED1 slot passes, then LED1 and flash drop
        chan = 5'b11111;
        reg_write(8'h0C, 8'h01);
        @(negedge clk);
        chan = 5'b01110;
        repeat (10) @(negedge clk);
        chk("R9 sequential sampling", 32'(rdata), 32'hF0);

        reg_rst = 1; @(negedge clk); reg_rst = 0; @(negedge clk);
        chk("R11 register reset clears", 32'(rdata), 32'h00);

        // R2 faulty device
        rst = 1; dev_ok = 0; t1 = 0; chan = 5'b11111;
        repeat (5) @(negedge clk);
        rst = 0;
        repeat (PH) @(negedge clk);
        phase(1'b1, 1'b0, "R2 faulty ack");
        phase(1'b0, 1'b0, "R1 low phase");
        phase(1'b1, 1'b1, "R3 LED1 after faulty ack");
        phase(1'b0, 1'b0, "R1 low phase");
        repeat (5) @(negedge clk);
        finish_up();
    end
endmodule